// File: doc/BRIEF.md
# I2C Master Start-Condition Generator

This block produces the opening event of an I2C master transaction: with both bus lines idle high, it pulls SDA low while SCL stays released. Software asks for a start with a one-cycle request. The block first checks that the bus is free. It then times two equal baud periods with a reloadable down-counter. At the end of the first period it pulls SDA low. At the end of the second period it stops counting, keeps SDA held low and raises a completion flag. Both bus inputs pass through a two-flop synchroniser before the block uses them. The outputs are open-drain enables, where 1 pulls the line low and 0 releases it.

The block aborts the start and returns to idle if the bus is not free when the request arrives, or if SCL goes low before SDA has been pulled low. It also protects its own registers while a start is running. A write to the transmit data buffer is refused and flagged as a write collision. Writes to the five command bits are dropped, so commands cannot be queued behind a start.

Top module: `i2c_start_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, both drive-low enables are 0 and busy is 0. The start-seen, done, bus-collision and write-collision flags are 0, and the data buffer and command register hold 0.
- R2: A start request accepted in idle, with synchronised SDA and SCL both high, sets busy at the next clock edge. The counter loads the 7-bit reload value, and SDA stays released for reload+1 cycles. A reload value of 0 gives a one-cycle period.
- R3: When the first period ends with both synchronised lines high, the SDA drive-low enable and start-seen rise together. The SCL drive-low enable stays 0.
- R4: The counter reloads and counts a second period of reload+1 cycles. When that period ends, busy falls and the done flag rises at the same edge, and SDA stays driven low afterwards.
- R5: A start request made while synchronised SDA or SCL is low sets the bus-collision flag at the next edge. Busy stays 0 and neither line is driven.
- R6: If synchronised SCL is low during the first period, the block aborts at the next edge. It sets the bus-collision flag, clears busy and start-seen, and releases SDA.
- R7: A data-buffer write while busy sets the write-collision flag and leaves the buffer unchanged. When busy is 0, the write updates the buffer and does not set the flag.
- R8: A command write while busy is ignored and the command register keeps its value. When busy is 0, the command write takes effect.
- R9: A start request is ignored whenever the block is not idle. This covers a start in progress, which is not restarted, and a completed start that is holding SDA low, which raises no collision.
- R10: The done, bus-collision and write-collision flags each stay set until their own clear input is pulsed. The clear inputs do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | One-cycle start request |
| reload_val | input | 7 | Baud counter reload value |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Data buffer write value |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command register write value |
| clr_done | input | 1 | Clear done flag |
| clr_bcol | input | 1 | Clear bus-collision flag |
| clr_wcol | input | 1 | Clear write-collision flag |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| busy | output | 1 | Start sequence in progress |
| start_seen | output | 1 | Start condition has been placed on the bus |
| done_flag | output | 1 | Sticky start-complete flag |
| bcol_flag | output | 1 | Sticky bus-collision flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| buf_q | output | 8 | Data buffer contents |
| cmd_q | output | 5 | Command register contents |

## Verification
The bench builds the block with its default parameters: a 7-bit reload, an 8-bit buffer, five command bits and two synchroniser stages. It runs starts with reload values 0, 3 and 127, so the one-cycle period and the longest period are both timed edge by edge. It uses a reload of 10 for the abort case, which leaves room for SCL to fall through the synchroniser before the first period ends. The bench models the wired bus itself, so a forced low level reaches the block only after the two synchroniser stages.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_HOLD = 2'd3
  } start_state_t;

  // One step of the baud down-counter; it rests at zero.
  function automatic logic [15:0] baud_step(input logic [15:0] cur);
    return (cur == 16'd0) ? 16'd0 : cur - 16'd1;
  endfunction

  // Cycles in one baud period for a given reload value.
  function automatic int unsigned baud_period(input int unsigned reload);
    return reload + 1;
  endfunction

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  // An idle bus floats high, so the chain resets to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                run,
  input  logic [RELOAD_W-1:0] load_val,
  output logic                expired
);
  import i2c_start_pkg::*;

  logic [RELOAD_W-1:0] cnt_q;
  logic [15:0]         step_w;

  assign step_w  = baud_step(16'(cnt_q));
  assign expired = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (run)  cnt_q <= step_w[RELOAD_W-1:0];
  end

  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_load_takes_value_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic sda_s,
  input  logic scl_s,
  input  logic expired,
  input  logic clr_done,
  input  logic clr_bcol,
  output logic load,
  output logic run,
  output logic busy,
  output logic sda_low,
  output logic start_seen,
  output logic done_flag,
  output logic bcol_flag
);
  import i2c_start_pkg::*;

  start_state_t state_q;
  logic         sda_low_q, seen_q, done_q, bcol_q;

  // Named events.
  logic req_idle, lines_high;
  logic ev_launch, ev_req_collide, ev_ph1_collide, ev_sda_fall, ev_finish;

  assign req_idle       = start_req && (state_q == ST_IDLE);
  assign lines_high     = sda_s && scl_s;
  assign ev_launch      = req_idle && lines_high;
  assign ev_req_collide = req_idle && !lines_high;
  assign ev_ph1_collide = (state_q == ST_PH1) && (!scl_s || (expired && !sda_s));
  assign ev_sda_fall    = (state_q == ST_PH1) && lines_high && expired;
  assign ev_finish      = (state_q == ST_PH2) && expired;

  assign load = ev_launch || ev_sda_fall;
  assign run  = (state_q == ST_PH1) || (state_q == ST_PH2);
  assign busy = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sda_low_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (ev_launch) begin
      state_q <= ST_PH1;
    end else if (ev_ph1_collide) begin
      state_q   <= ST_IDLE;
      sda_low_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (ev_sda_fall) begin
      state_q   <= ST_PH2;
      sda_low_q <= 1'b1;
      seen_q    <= 1'b1;
    end else if (ev_finish) begin
      state_q <= ST_HOLD;
    end
  end

  // Sticky flags: a set wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      bcol_q <= 1'b0;
    end else begin
      if (ev_finish) done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (ev_req_collide || ev_ph1_collide) bcol_q <= 1'b1;
      else if (clr_bcol) bcol_q <= 1'b0;
    end
  end

  assign sda_low    = sda_low_q;
  assign start_seen = seen_q;
  assign done_flag  = done_q;
  assign bcol_flag  = bcol_q;

  p_sda_low_with_seen_r3: assert property (@(posedge clk) disable iff (rst)
    sda_low_q |-> seen_q);

  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $fell(busy));

  p_req_collide_r5: assert property (@(posedge clk) disable iff (rst)
    ev_req_collide |=> (bcol_q && !busy && !sda_low_q));

  p_abort_on_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PH1 && !scl_s) |=> (state_q == ST_IDLE && bcol_q && !seen_q));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (start_req && state_q == ST_HOLD) |=> (state_q == ST_HOLD && $stable(bcol_q)));
endmodule

// File: rtl/i2c_start_regs.sv
module i2c_start_regs #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              clr_wcol,
  output logic [DATA_W-1:0] buf_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              wcol_flag
);
  logic buf_take, buf_refuse, cmd_take;

  assign buf_take   = buf_wr && !busy;
  assign buf_refuse = buf_wr && busy;
  assign cmd_take   = cmd_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q     <= '0;
      cmd_q     <= '0;
      wcol_flag <= 1'b0;
    end else begin
      if (buf_take) buf_q <= buf_wdata;
      if (cmd_take) cmd_q <= cmd_wdata;
      if (buf_refuse) wcol_flag <= 1'b1;
      else if (clr_wcol) wcol_flag <= 1'b0;
    end
  end

  p_wcol_buf_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && buf_wr) |=> ($stable(buf_q) && wcol_flag));

  p_cmd_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(cmd_q));

  p_wcol_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (wcol_flag && !clr_wcol) |=> wcol_flag);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RELOAD_W    = 7,
  parameter int DATA_W      = 8,
  parameter int CMD_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                sda_in,
  input  logic                scl_in,
  input  logic                buf_wr,
  input  logic [DATA_W-1:0]   buf_wdata,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_wdata,
  input  logic                clr_done,
  input  logic                clr_bcol,
  input  logic                clr_wcol,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  output logic                busy,
  output logic                start_seen,
  output logic                done_flag,
  output logic                bcol_flag,
  output logic                wcol_flag,
  output logic [DATA_W-1:0]   buf_q,
  output logic [CMD_W-1:0]    cmd_q
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  logic             load_w, run_w, expired_w, busy_w;

  i2c_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}), .q(lines_s)
  );

  i2c_baud_cnt #(.RELOAD_W(RELOAD_W)) u_baud (
    .clk(clk), .rst(rst), .load(load_w), .run(run_w),
    .load_val(reload_val), .expired(expired_w)
  );

  i2c_start_fsm u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req),
    .sda_s(lines_s[1]), .scl_s(lines_s[0]), .expired(expired_w),
    .clr_done(clr_done), .clr_bcol(clr_bcol),
    .load(load_w), .run(run_w), .busy(busy_w),
    .sda_low(sda_drive_low), .start_seen(start_seen),
    .done_flag(done_flag), .bcol_flag(bcol_flag)
  );

  i2c_start_regs #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_regs (
    .clk(clk), .rst(rst), .busy(busy_w),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .clr_wcol(clr_wcol),
    .buf_q(buf_q), .cmd_q(cmd_q), .wcol_flag(wcol_flag)
  );

  // The start sequence never pulls SCL.
  assign scl_drive_low = 1'b0;
  assign busy          = busy_w;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sda_drive_low && !busy && !done_flag && !bcol_flag && !wcol_flag));
endmodule

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic [6:0] reload_val = 7'd3;
  logic       frc_sda = 1'b0, frc_scl = 1'b0;
  logic       buf_wr = 1'b0, cmd_wr = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic [4:0] cmd_wdata = 5'h00;
  logic       clr_done = 1'b0, clr_bcol = 1'b0, clr_wcol = 1'b0;
  logic       sda_drive_low, scl_drive_low, busy, start_seen;
  logic       done_flag, bcol_flag, wcol_flag;
  logic [7:0] buf_q;
  logic [4:0] cmd_q;
  logic       sda_in, scl_in;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // Wired-AND bus: anyone pulling low wins.
  assign sda_in = !(sda_drive_low || frc_sda);
  assign scl_in = !(scl_drive_low || frc_scl);

  i2c_start_gen dut (
    .clk(clk), .rst(rst), .start_req(start_req), .reload_val(reload_val),
    .sda_in(sda_in), .scl_in(scl_in), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .clr_done(clr_done),
    .clr_bcol(clr_bcol), .clr_wcol(clr_wcol), .sda_drive_low(sda_drive_low),
    .scl_drive_low(scl_drive_low), .busy(busy), .start_seen(start_seen),
    .done_flag(done_flag), .bcol_flag(bcol_flag), .wcol_flag(wcol_flag),
    .buf_q(buf_q), .cmd_q(cmd_q)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; frc_sda = 1'b0; frc_scl = 1'b0;
    tick(); tick();
    rst = 1'b0;
    tick(); tick(); tick();
  endtask

  task automatic pulse_req();
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check("R1", "sda_drive", sda_drive_low, 0);
    check("R1", "scl_drive", scl_drive_low, 0);
    check("R1", "busy", busy, 0);
    check("R1", "flags", {start_seen, done_flag, bcol_flag, wcol_flag}, 0);
    check("R1", "buf/cmd", {buf_q, 3'b0, cmd_q}, 0);
  endtask

  // R2, R3, R4: full start with a given reload value
  task automatic t_start(input int n);
    int per;
    do_reset();
    per = n + 1;
    reload_val = 7'(n);
    pulse_req();
    check("R2", "busy after request", busy, 1);
    for (int i = 1; i < per; i++) begin
      tick();
      check("R2", "sda released in period 1", sda_drive_low, 0);
    end
    tick();
    check("R3", "sda pulled low", sda_drive_low, 1);
    check("R3", "start_seen", start_seen, 1);
    check("R3", "scl released", scl_drive_low, 0);
    for (int i = 1; i < per; i++) begin
      tick();
      check("R4", "done not yet", done_flag, 0);
      check("R4", "busy in period 2", busy, 1);
    end
    tick();
    check("R4", "done set", done_flag, 1);
    check("R4", "busy cleared", busy, 0);
    tick(); tick();
    check("R4", "sda held low", sda_drive_low, 1);
  endtask

  // R5: request on a busy bus
  task automatic t_req_collide(input bit low_sda);
    do_reset();
    reload_val = 7'd3;
    if (low_sda) frc_sda = 1'b1; else frc_scl = 1'b1;
    tick(); tick(); tick();
    pulse_req();
    check("R5", "bcol set", bcol_flag, 1);
    check("R5", "busy stays 0", busy, 0);
    check("R5", "no drive", sda_drive_low, 0);
    frc_sda = 1'b0; frc_scl = 1'b0;
  endtask

  // R6: SCL falls during the first period
  task automatic t_abort();
    do_reset();
    reload_val = 7'd10;
    pulse_req();
    frc_scl = 1'b1;
    tick(); tick(); tick(); tick();
    check("R6", "busy cleared", busy, 0);
    check("R6", "bcol set", bcol_flag, 1);
    check("R6", "start_seen clear", start_seen, 0);
    check("R6", "sda released", sda_drive_low, 0);
    frc_scl = 1'b0;
  endtask

  // R7, R8, R9: writes and requests while busy, then after completion
  task automatic t_lockout();
    do_reset();
    reload_val = 7'd3;
    buf_wdata = 8'h5A; buf_wr = 1'b1; cmd_wdata = 5'h11; cmd_wr = 1'b1;
    tick();
    buf_wr = 1'b0; cmd_wr = 1'b0;
    check("R7", "idle buffer write", buf_q, 8'h5A);
    check("R7", "no wcol when idle", wcol_flag, 0);
    check("R8", "idle command write", cmd_q, 5'h11);
    pulse_req();
    buf_wdata = 8'hC3; buf_wr = 1'b1; cmd_wdata = 5'h0E; cmd_wr = 1'b1;
    tick();
    buf_wr = 1'b0; cmd_wr = 1'b0;
    check("R7", "buffer unchanged", buf_q, 8'h5A);
    check("R7", "wcol set", wcol_flag, 1);
    check("R8", "command ignored", cmd_q, 5'h11);
    start_req = 1'b1;        // ignored in the first period
    tick();
    start_req = 1'b0;
    // request edge plus 8 cycles finish the start; 2 used so far
    for (int i = 0; i < 5; i++) tick();
    check("R9", "no restart, still busy", busy, 1);
    tick();
    check("R9", "done on original schedule", done_flag, 1);
    pulse_req();             // ignored while holding SDA low
    check("R9", "hold request gives no bcol", bcol_flag, 0);
    check("R9", "hold request not busy", busy, 0);
    cmd_wdata = 5'h07; cmd_wr = 1'b1;
    tick();
    cmd_wr = 1'b0;
    check("R8", "command after completion", cmd_q, 5'h07);
  endtask

  // R10: sticky flags with separate clears
  task automatic t_sticky();
    t_req_collide(1'b0);
    buf_wr = 1'b0;
    tick(); tick(); tick();
    check("R10", "bcol sticky", bcol_flag, 1);
    clr_wcol = 1'b1; tick(); clr_wcol = 1'b0;
    check("R10", "bcol kept by wcol clear", bcol_flag, 1);
    clr_bcol = 1'b1; tick(); clr_bcol = 1'b0;
    check("R10", "bcol cleared", bcol_flag, 0);
    t_start(0);
    clr_bcol = 1'b1; tick(); clr_bcol = 1'b0;
    check("R10", "done kept by bcol clear", done_flag, 1);
    clr_done = 1'b1; tick(); clr_done = 1'b0;
    check("R10", "done cleared", done_flag, 0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start(3);
    t_start(0);
    t_start(127);
    t_req_collide(1'b0);
    t_req_collide(1'b1);
    t_abort();
    t_lockout();
    t_sticky();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule